// File: doc/BRIEF.md
# Smart-Card Interface Interrupt and Fault Controller

This block collects fault and status events for a contact smart-card interface and drives one active-low, registered interrupt line toward the host. Three supply fault levels feed it: the card supply, the logic supply and the charge-pump supply. Four event inputs report a change: early answer-to-reset, mute answer-to-reset, card inserted or removed, and an over-current or over-heat protection trip. Each event's rising edge is caught in a sticky status bit, and the host clears all status bits with a one-cycle read strobe.

There are two ways the interrupt is released. If only status bits are holding it low, it returns high once the host has read the status. A logic-supply fault behaves differently. It latches a hold flag, and that flag is released only after the fault input has stayed low for a programmable number of consecutive clock cycles. When any supply fault rises, the block also sends a one-cycle deactivation request to the card sequencer. Power-on reset returns every register to its default value. A logic-supply fault does not touch the status bits.

Top module: `card_irq_unit`

## Requirements
- R1: While porN is low, and in the first cycle after it is released, irqN is 1, statusBits is 0 and deactReq is 0.
- R2: When any of cardSupplyFault, logicSupplyFault or pumpSupplyFault is high at a rising clock edge, irqN is 0 after that edge.
- R3: A rising edge on an event input sets its status bit at the edge where the high level is first sampled. The bit order is [0] early answer-to-reset, [1] mute answer-to-reset, [2] card inserted/removed, [3] protection trip. An event that is held high does not set its bit again after a read.
- R4: Status bits are sticky. They keep their value until an edge at which statusRead is high, and that edge clears them all. An event edge sampled together with statusRead leaves its bit set.
- R5: irqN goes to 0 one edge after any status bit becomes 1. When status bits are the only cause, irqN returns to 1 one edge after the read that clears them.
- R6: A logic-supply fault keeps irqN at 0 until logicSupplyFault has been sampled low on T1_CYCLES consecutive edges. irqN returns to 1 at the next edge after that, provided no other cause remains.
- R7: If logicSupplyFault is sampled high again before the interval completes, the interval starts over from zero.
- R8: A logic-supply fault leaves the status bits unchanged.
- R9: deactReq is a one-cycle pulse. It comes one edge after a fault input is first sampled high, it is not repeated while that fault stays high, and a different fault that rises later produces a new pulse.
- R10: irqN stays at 0 while any supply fault is active, even after a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| cardSupplyFault | input | 1 | Card supply fault level |
| logicSupplyFault | input | 1 | Logic supply fault level |
| pumpSupplyFault | input | 1 | Pump supply fault level |
| earlyAtrEvt | input | 1 | Early answer-to-reset event |
| muteAtrEvt | input | 1 | Mute answer-to-reset event |
| cardChangeEvt | input | 1 | Card inserted or removed event |
| protectEvt | input | 1 | Over-current / over-heat protection event |
| statusRead | input | 1 | Host read of status, one-cycle strobe that clears the bits |
| irqN | output | 1 | Registered interrupt, active low |
| statusBits | output | 4 | Sticky status bits (order given in R3) |
| deactReq | output | 1 | One-cycle deactivation request to the card sequencer |

## Verification
Status bits and deactReq change at the edge where their cause is first sampled. A fault moves irqN at that same edge, but a status bit moves irqN one edge later because it passes through the status register first. The logic-supply release comes at the edge after the T1_CYCLES-th consecutive low sample. Inputs are driven on the falling edge, and every output is compared on the following falling edge against the bench's per-cycle model. The directed sequences count edges explicitly, so the edges just before and just after each release are both checked.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
  localparam int N_EVT = 4;  // early ATR, mute ATR, card change, protection
  localparam int N_FLT = 3;  // card supply, logic supply, pump supply
  localparam int FLT_LOGIC = 1;

  typedef struct packed {
    logic clearStatus;
    logic timerClear;
    logic timerStep;
  } irqStrobes_t;
endpackage

// File: rtl/card_irq_path.sv
module card_irq_path
  import card_irq_pkg::*;
#(
  parameter int T1_CYCLES = 64
) (
  input  logic             clk,
  input  logic             porN,
  input  irqStrobes_t      strobes,
  input  logic [N_EVT-1:0] evIn,
  input  logic [N_FLT-1:0] faultIn,
  output logic [N_EVT-1:0] statusQ,
  output logic             statusAny,
  output logic             faultRise,
  output logic             timerDone
);
  localparam int CW = $clog2(T1_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(T1_CYCLES - 1);

  logic [N_EVT-1:0] evPrev;
  logic [N_EVT-1:0] evRise;
  logic [N_FLT-1:0] faultPrev;
  logic [CW-1:0]    tmrQ;

  assign evRise = evIn & ~evPrev;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      evPrev    <= '0;
      faultPrev <= '0;
    end else begin
      evPrev    <= evIn;
      faultPrev <= faultIn;
    end
  end

  // One sticky latch per event; a new edge wins over a read in the same cycle.
  for (genvar i = 0; i < N_EVT; i++) begin : g_stat
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) statusQ[i] <= 1'b0;
      else       statusQ[i] <= evRise[i] | (statusQ[i] & ~strobes.clearStatus);
    end

    // R4: a set bit survives any cycle without a read
    a_r4_sticky: assert property (@(posedge clk) disable iff (!porN)
      (statusQ[i] && !strobes.clearStatus) |=> statusQ[i]);
  end

  assign statusAny = |statusQ;
  assign faultRise = |(faultIn & ~faultPrev);

  // Supply-valid interval counter.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                  tmrQ <= '0;
    else if (strobes.timerClear) tmrQ <= '0;
    else if (strobes.timerStep)  tmrQ <= tmrQ + 1'b1;
  end

  assign timerDone = (tmrQ == LAST);

  // R7: a restart strobe always returns the interval count to zero
  a_r7_restart: assert property (@(posedge clk) disable iff (!porN)
    strobes.timerClear |=> (tmrQ == '0));

  // R6: the interval counter never passes its terminal value
  a_r6_bound: assert property (@(posedge clk) disable iff (!porN)
    tmrQ <= LAST);
endmodule

// File: rtl/card_irq_ctrl.sv
module card_irq_ctrl
  import card_irq_pkg::*;
(
  input  logic             clk,
  input  logic             porN,
  input  logic             statusRead,
  input  logic [N_FLT-1:0] faultIn,
  input  logic             statusAny,
  input  logic             faultRise,
  input  logic             timerDone,
  output irqStrobes_t      strobes,
  output logic             irqN,
  output logic             deactReq
);
  logic logicFault;
  logic holdQ;

  assign logicFault = faultIn[FLT_LOGIC];

  always_comb begin
    strobes.clearStatus = statusRead;
    strobes.timerClear  = logicFault | (holdQ & timerDone);
    strobes.timerStep   = holdQ & ~logicFault;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      holdQ    <= 1'b0;
      irqN     <= 1'b1;
      deactReq <= 1'b0;
    end else begin
      if (logicFault)             holdQ <= 1'b1;
      else if (holdQ && timerDone) holdQ <= 1'b0;
      irqN     <= ~((|faultIn) | holdQ | statusAny);
      deactReq <= faultRise;
    end
  end

  // R2: any fault level pulls the interrupt low at the next edge
  a_r2_fault_irq: assert property (@(posedge clk) disable iff (!porN)
    (|faultIn) |=> !irqN);

  // R5: a latched status bit pulls the interrupt low at the next edge
  a_r5_status_irq: assert property (@(posedge clk) disable iff (!porN)
    statusAny |=> !irqN);

  // R6: a logic-supply fault arms the hold
  a_r6_hold_arm: assert property (@(posedge clk) disable iff (!porN)
    logicFault |=> holdQ);

  // R9: a newly risen fault level yields a deactivation pulse
  a_r9_rise: assert property (@(posedge clk) disable iff (!porN)
    (|(faultIn & ~$past(faultIn))) |=> deactReq);
endmodule

// File: rtl/card_irq_unit.sv
module card_irq_unit
  import card_irq_pkg::*;
#(
  parameter int T1_CYCLES = 64
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       cardSupplyFault,
  input  logic       logicSupplyFault,
  input  logic       pumpSupplyFault,
  input  logic       earlyAtrEvt,
  input  logic       muteAtrEvt,
  input  logic       cardChangeEvt,
  input  logic       protectEvt,
  input  logic       statusRead,
  output logic       irqN,
  output logic [3:0] statusBits,
  output logic       deactReq
);
  irqStrobes_t      strobes;
  logic [N_EVT-1:0] evIn;
  logic [N_FLT-1:0] faultIn;
  logic [N_EVT-1:0] statusQ;
  logic             statusAny;
  logic             faultRise;
  logic             timerDone;

  assign evIn    = {protectEvt, cardChangeEvt, muteAtrEvt, earlyAtrEvt};
  assign faultIn = {pumpSupplyFault, logicSupplyFault, cardSupplyFault};
  assign statusBits = statusQ;

  card_irq_path #(.T1_CYCLES(T1_CYCLES)) u_path (
    .clk       (clk),
    .porN      (porN),
    .strobes   (strobes),
    .evIn      (evIn),
    .faultIn   (faultIn),
    .statusQ   (statusQ),
    .statusAny (statusAny),
    .faultRise (faultRise),
    .timerDone (timerDone)
  );

  card_irq_ctrl u_ctrl (
    .clk        (clk),
    .porN       (porN),
    .statusRead (statusRead),
    .faultIn    (faultIn),
    .statusAny  (statusAny),
    .faultRise  (faultRise),
    .timerDone  (timerDone),
    .strobes    (strobes),
    .irqN       (irqN),
    .deactReq   (deactReq)
  );
endmodule

// File: tb/card_irq_unit_test.sv
`timescale 1ns/1ps
module card_irq_unit_test;
  localparam int T1 = 20;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic [2:0] flt = '0;   // [0] card, [1] logic, [2] pump
  logic [3:0] ev = '0;    // R3 order
  logic       rd = 1'b0;
  logic       irqN;
  logic [3:0] statusBits;
  logic       deactReq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit cmpOn = 0;

  // reference model state
  logic [3:0] mStat, mEvPrev;
  logic [2:0] mFPrev;
  logic       mHold, mIrqN, mDeact;
  int         mCnt;

  always #2 clk = ~clk;

  card_irq_unit #(.T1_CYCLES(T1)) uut (
    .clk(clk), .porN(porN),
    .cardSupplyFault(flt[0]), .logicSupplyFault(flt[1]), .pumpSupplyFault(flt[2]),
    .earlyAtrEvt(ev[0]), .muteAtrEvt(ev[1]), .cardChangeEvt(ev[2]), .protectEvt(ev[3]),
    .statusRead(rd), .irqN(irqN), .statusBits(statusBits), .deactReq(deactReq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mStat = '0; mEvPrev = '0; mFPrev = '0;
    mHold = 0; mIrqN = 1; mDeact = 0; mCnt = 0;
  endtask

  function automatic logic [3:0] nextStat(logic [3:0] s, logic [3:0] e, logic [3:0] p, logic r);
    return (e & ~p) | (r ? 4'b0 : s);
  endfunction

  task automatic modelStep();
    logic nHold; int nCnt;
    nHold = mHold; nCnt = mCnt;
    if (flt[1]) begin nHold = 1; nCnt = 0; end
    else if (mHold) begin
      if (mCnt == T1 - 1) begin nHold = 0; nCnt = 0; end
      else nCnt = mCnt + 1;
    end
    mIrqN   = ~((|flt) | mHold | (|mStat));
    mDeact  = |(flt & ~mFPrev);
    mStat   = nextStat(mStat, ev, mEvPrev, rd);
    mEvPrev = ev; mFPrev = flt;
    mHold = nHold; mCnt = nCnt;
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    if (cmpOn) begin
      check("R5 irqN vs model", 32'(irqN), 32'(mIrqN));
      check("R4 status vs model", 32'(statusBits), 32'(mStat));
      check("R9 deactReq vs model", 32'(deactReq), 32'(mDeact));
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_c0de);
    modelReset();
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 irqN in reset", 32'(irqN), 32'd1);
    check("R1 status in reset", 32'(statusBits), 32'd0);
    check("R1 deactReq in reset", 32'(deactReq), 32'd0);
    porN = 1'b1;
    tick();
    check("R1 irqN after reset", 32'(irqN), 32'd1);
    check("R1 status after reset", 32'(statusBits), 32'd0);
    check("R1 deactReq after reset", 32'(deactReq), 32'd0);

    // R3 / R5: early ATR edge
    ev[0] = 1; tick();
    check("R3 early ATR bit", 32'(statusBits), 32'h1);
    check("R5 irq not yet low", 32'(irqN), 32'd1);
    tick();
    check("R5 irq low from status", 32'(irqN), 32'd0);
    rd = 1; tick(); rd = 0;
    check("R4 read clears", 32'(statusBits), 32'h0);
    check("R5 irq low in read cycle", 32'(irqN), 32'd0);
    tick();
    check("R5 irq released after read", 32'(irqN), 32'd1);
    check("R3 held event not recaptured", 32'(statusBits), 32'h0);
    ev[0] = 0; tick();

    // R4: event coincident with read stays set
    ev[2] = 1; rd = 1; tick(); rd = 0; ev[2] = 0;
    check("R4 event with read stays", 32'(statusBits), 32'h4);
    ev[1] = 1; tick(); ev[1] = 0;
    check("R4 sticky accumulates", 32'(statusBits), 32'h6);
    rd = 1; tick(); rd = 0; tick();
    check("R4 cleared", 32'(statusBits), 32'h0);

    // R2 / R9 / R10: card supply fault
    flt[0] = 1; tick();
    check("R2 card fault irq", 32'(irqN), 32'd0);
    check("R9 deact pulse", 32'(deactReq), 32'd1);
    tick();
    check("R9 no repeat", 32'(deactReq), 32'd0);
    ev[3] = 1; tick(); ev[3] = 0;
    check("R3 protection bit", 32'(statusBits), 32'h8);
    rd = 1; tick(); rd = 0; tick();
    check("R10 irq held by fault after read", 32'(irqN), 32'd0);
    check("R9 still no repeat", 32'(deactReq), 32'd0);
    // R9: second distinct fault while first held
    flt[2] = 1; tick();
    check("R9 new pulse for pump fault", 32'(deactReq), 32'd1);
    check("R2 pump fault irq", 32'(irqN), 32'd0);
    flt = '0; tick(); tick();
    check("R2 irq released after faults", 32'(irqN), 32'd1);

    // R6 / R8: logic supply fault with a status bit latched
    ev[1] = 1; tick(); ev[1] = 0;
    flt[1] = 1; tick();
    check("R9 logic fault pulse", 32'(deactReq), 32'd1);
    tick();
    check("R8 status kept under logic fault", 32'(statusBits), 32'h2);
    rd = 1; tick(); rd = 0;
    flt[1] = 0;
    ticks(T1);
    check("R6 irq still low at interval end", 32'(irqN), 32'd0);
    tick();
    check("R6 irq released after interval", 32'(irqN), 32'd1);

    // R7: restart of the interval
    flt[1] = 1; tick(); flt[1] = 0;
    ticks(10);
    flt[1] = 1; tick(); flt[1] = 0;
    check("R9 repeat pulse after fault re-rise", 32'(deactReq), 32'd1);
    ticks(T1);
    check("R7 irq low, interval restarted", 32'(irqN), 32'd0);
    tick();
    check("R7 irq released after full interval", 32'(irqN), 32'd1);

    // random phase against the model
    cmpOn = 1;
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < 4; b++) if ($urandom_range(0, 7) == 0) ev[b] = ~ev[b];
      for (int b = 0; b < 3; b++) begin
        if (flt[b]) begin if ($urandom_range(0, 5) == 0) flt[b] = 0; end
        else if ($urandom_range(0, 60) == 0) flt[b] = 1;
      end
      rd = ($urandom_range(0, 9) == 0);
      tick();
    end
    cmpOn = 0;

    // R1: reset mid-activity
    flt = 3'b010; ev = 4'hf; tick();
    porN = 0; modelReset(); flt = '0; ev = '0; rd = 0;
    @(negedge clk);
    check("R1 irqN in late reset", 32'(irqN), 32'd1);
    check("R1 status in late reset", 32'(statusBits), 32'd0);
    porN = 1; tick();
    check("R1 irqN after late reset", 32'(irqN), 32'd1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule